// File: doc/BRIEF.md
# Power-Up Supply Qualification Gate

This block governs the power-up stage of a power management unit. Three synchronised "supply in range" flags come in: the management logic's own supply, the core supply, and the supply that feeds the voltage detector circuits. Each flag has to stay high for a programmable number of consecutive clock cycles before its supply counts as qualified. A low sample before that point clears that supply's progress, and counting starts again.

While any supply is still unqualified, the detector bank stays disabled. Every low-voltage and high-voltage detector output is clamped to 0. Once all three supplies are qualified, the block asserts a registered detector enable. One cycle later it unmasks the detector outputs and raises a power-good status toward the reset controller. From then on the detector channels monitor the supplies. The power-up flags no longer matter until the next reset. The analog comparators are outside the block and appear here only as digital flags.

Top module: `pwrup_qual_gate`

## Requirements
- R1: While reset is high and in the first cycle after it, `det_en`, `pwr_good`, `lv_out` and `hv_out` are all 0.
- R2: A supply is qualified once its flag has been sampled high on STABLE consecutive clock edges. `det_en` rises on the edge after the one at which the last of the three supplies completes its STABLE-th consecutive high sample.
- R3: A low sample of a supply flag before enabling sets that supply's consecutive count back to zero. It then needs STABLE fresh high samples.
- R4: While `det_en` was low at the previous edge, every bit of `lv_out` and `hv_out` is 0, whatever the raw detector inputs are.
- R5: When `det_en` was high at an edge, `lv_out` and `hv_out` show the raw detector inputs sampled at that edge. The outputs are therefore unmasked one cycle after the enable.
- R6: `pwr_good` rises exactly one cycle after `det_en`, in the same cycle as the first unmasked detector output, and it is never high while `det_en` is low.
- R7: Once `det_en` is high, it and `pwr_good` stay high until reset, and later changes of the supply flags have no effect.
- R8: `supply_ok` bit 0 is the management supply, bit 1 is the core supply and bit 2 is the detector supply. All three must be qualified, so any two alone never enable the detectors.
- R9: The number of low-voltage channels (NUM_LV) and high-voltage channels (NUM_HV) are parameters, 4 each by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 3 | In-range flags: bit 0 management, bit 1 core, bit 2 detector supply |
| lv_raw | input | NUM_LV | Raw low-voltage detector outputs |
| hv_raw | input | NUM_HV | Raw high-voltage detector outputs |
| det_en | output | 1 | Registered enable for the detector bank |
| lv_out | output | NUM_LV | Gated low-voltage detect outputs |
| hv_out | output | NUM_HV | Gated high-voltage detect outputs |
| pwr_good | output | 1 | Power properly applied, toward the reset controller |

## Verification
The bench builds the block with STABLE = 3 and two channels of each kind. This keeps every qualification run only a few cycles long. It also lets all sixteen raw detector patterns be swept in the clamped phase and again in the live phase. The short stability window lets the bench drop a supply one sample short of qualification, stagger the three rise times, and hold each pair of supplies high without the third. It compares every cycle against an arithmetic model of the consecutive-sample counts.

// File: rtl/pwrup_qual_pkg.sv
package pwrup_qual_pkg;

  localparam int NUM_SUPPLIES = 3;

  typedef enum logic [1:0] {
    SUP_MGMT = 2'd0,
    SUP_CORE = 2'd1,
    SUP_DET  = 2'd2
  } supply_idx_e;

  typedef enum logic [1:0] {
    ST_CLAMP  = 2'b00,
    ST_ARMING = 2'b01,
    ST_LIVE   = 2'b11
  } gate_state_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pwrup_supply_qualifier.sv
module pwrup_supply_qualifier #(
  parameter int STABLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_in,
  output logic qualified
);
  import pwrup_qual_pkg::*;

  localparam int CW = cnt_width(STABLE);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!flag_in) begin
      run_cnt <= '0;
    end else if (run_cnt != LIMIT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign qualified = (run_cnt == LIMIT);

  a_r3_drop_clears: assert property (@(posedge clk) disable iff (rst)
    !flag_in |=> !qualified);

  a_r2_rise_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> $past(flag_in));

endmodule

// File: rtl/pwrup_sequencer.sv
module pwrup_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic all_qualified,
  output logic det_en,
  output logic pwr_good
);
  import pwrup_qual_pkg::*;

  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CLAMP:  if (all_qualified) state_d = ST_ARMING;
      ST_ARMING: state_d = ST_LIVE;
      ST_LIVE:   state_d = ST_LIVE;
      default:   state_d = ST_CLAMP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_CLAMP;
      det_en   <= 1'b0;
      pwr_good <= 1'b0;
    end else begin
      state_q  <= state_d;
      det_en   <= (state_d != ST_CLAMP);
      pwr_good <= (state_d == ST_LIVE);
    end
  end

  a_r7_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    det_en |=> det_en);

  a_r2_enable_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(det_en) |-> $past(all_qualified));

  a_r6_good_follows_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> $past(det_en));

  a_r6_good_implies_enable: assert property (@(posedge clk) disable iff (rst)
    pwr_good |-> det_en);

endmodule

// File: rtl/pwrup_detect_gate.sv
module pwrup_detect_gate #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] gated_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) gated_out[g] <= 1'b0;
      else     gated_out[g] <= enable & raw_in[g];
    end
  end

  a_r4_clamped: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (gated_out == '0));

  a_r5_passthrough: assert property (@(posedge clk) disable iff (rst)
    enable |=> (gated_out == $past(raw_in)));

endmodule

// File: rtl/pwrup_qual_gate.sv
module pwrup_qual_gate #(
  parameter int STABLE = 16,
  parameter int NUM_LV = 4,
  parameter int NUM_HV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        supply_ok,
  input  logic [NUM_LV-1:0] lv_raw,
  input  logic [NUM_HV-1:0] hv_raw,
  output logic              det_en,
  output logic [NUM_LV-1:0] lv_out,
  output logic [NUM_HV-1:0] hv_out,
  output logic              pwr_good
);
  import pwrup_qual_pkg::*;

  logic [NUM_SUPPLIES-1:0] qual_vec;
  logic                    all_qual;

  for (genvar s = 0; s < NUM_SUPPLIES; s++) begin : g_sup
    pwrup_supply_qualifier #(.STABLE(STABLE)) u_qual (
      .clk       (clk),
      .rst       (rst),
      .flag_in   (supply_ok[s]),
      .qualified (qual_vec[s])
    );
  end

  assign all_qual = &qual_vec;

  pwrup_sequencer u_seq (
    .clk           (clk),
    .rst           (rst),
    .all_qualified (all_qual),
    .det_en        (det_en),
    .pwr_good      (pwr_good)
  );

  pwrup_detect_gate #(.WIDTH(NUM_LV)) u_lv_gate (
    .clk       (clk),
    .rst       (rst),
    .enable    (det_en),
    .raw_in    (lv_raw),
    .gated_out (lv_out)
  );

  pwrup_detect_gate #(.WIDTH(NUM_HV)) u_hv_gate (
    .clk       (clk),
    .rst       (rst),
    .enable    (det_en),
    .raw_in    (hv_raw),
    .gated_out (hv_out)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!det_en && !pwr_good && lv_out == '0 && hv_out == '0));

  a_r8_all_needed: assert property (@(posedge clk) disable iff (rst)
    $rose(det_en) |-> $past(&qual_vec));

endmodule

// File: tb/pwrup_qual_gate_tb.sv
module pwrup_qual_gate_tb;
  localparam int S   = 3;
  localparam int NLV = 2;
  localparam int NHV = 2;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] sup;
  logic [NLV-1:0] lv;
  logic [NHV-1:0] hv;
  logic det_en, pwr_good;
  logic [NLV-1:0] lv_out;
  logic [NHV-1:0] hv_out;

  always #10 clk = ~clk;

  pwrup_qual_gate #(.STABLE(S), .NUM_LV(NLV), .NUM_HV(NHV)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(sup), .lv_raw(lv), .hv_raw(hv),
    .det_en(det_en), .lv_out(lv_out), .hv_out(hv_out), .pwr_good(pwr_good)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  int m_run [3];
  logic m_en, m_pg;
  logic [NLV-1:0] m_lv;
  logic [NHV-1:0] m_hv;

  task automatic model_edge();
    bit allq;
    if (rst) begin
      for (int i = 0; i < 3; i++) m_run[i] = 0;
      m_en = 0; m_pg = 0; m_lv = '0; m_hv = '0;
    end else begin
      allq = 1;
      for (int i = 0; i < 3; i++) if (m_run[i] < S) allq = 0;
      m_pg = m_en;
      m_lv = m_en ? lv : '0;
      m_hv = m_en ? hv : '0;
      m_en = m_en | allq;
      for (int i = 0; i < 3; i++)
        m_run[i] = sup[i] ? ((m_run[i] < S) ? m_run[i] + 1 : S) : 0;
    end
  endtask

  task automatic step(input logic r, input logic [2:0] s,
                      input logic [NLV-1:0] l, input logic [NHV-1:0] h,
                      input string tag);
    rst = r; sup = s; lv = l; hv = h;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    if (det_en !== m_en || pwr_good !== m_pg || lv_out !== m_lv || hv_out !== m_hv) begin
      errors++;
      $display("FAIL %s: got en=%b pg=%b lv=%b hv=%b, expected en=%b pg=%b lv=%b hv=%b",
               tag, det_en, pwr_good, lv_out, hv_out, m_en, m_pg, m_lv, m_hv);
    end
  endtask

  task automatic expect_state(input logic en, input logic pg, input string tag);
    vectors++;
    if (det_en !== en || pwr_good !== pg) begin
      errors++;
      $display("FAIL %s: got en=%b pg=%b, expected en=%b pg=%b", tag, det_en, pwr_good, en, pg);
    end
  endtask

  initial begin
    rst = 1; sup = '0; lv = '0; hv = '0;
    m_en = 0; m_pg = 0; m_lv = '0; m_hv = '0;
    for (int i = 0; i < 3; i++) m_run[i] = 0;
    @(negedge clk);
    // R1: reset state, with raw detectors active
    for (int k = 0; k < 3; k++) step(1, 3'b111, '1, '1, "R1");
    // R8: any two supplies alone never enable
    for (int miss = 0; miss < 3; miss++) begin
      logic [2:0] p;
      p = 3'b111 & ~(3'b001 << miss);
      for (int k = 0; k < S + 4; k++) step(0, p, '1, '1, "R8");
      expect_state(0, 0, "R8");
    end
    step(0, 3'b000, '0, '0, "R3");
    // R3: management supply drops one sample short
    for (int k = 0; k < S - 1; k++) step(0, 3'b111, '1, '0, "R3");
    step(0, 3'b110, '1, '0, "R3");
    for (int k = 0; k < S - 1; k++) step(0, 3'b111, '0, '1, "R3");
    expect_state(0, 0, "R3");
    // R4: clamp sweep while core supply restarts repeatedly
    for (int pat = 0; pat < 16; pat++)
      step(0, (pat % 3 == 0) ? 3'b101 : 3'b111, pat[NLV-1:0], pat[NLV+NHV-1:NLV], "R4");
    // R2: staggered rises: mgmt, then core, then detector supply last
    step(0, 3'b000, '0, '0, "R2");
    step(0, 3'b001, '1, '1, "R2");
    step(0, 3'b011, '1, '1, "R2");
    for (int k = 0; k < S + 3; k++) step(0, 3'b111, 2'b10, 2'b01, "R2");
    expect_state(1, 1, "R2");
    // R5, R6: live sweep of all raw patterns
    for (int pat = 0; pat < 16; pat++)
      step(0, 3'b111, pat[NLV-1:0], pat[NLV+NHV-1:NLV], "R5");
    // R7: supplies drop after enabling; outputs stay live
    for (int pat = 15; pat >= 0; pat--)
      step(0, pat[2:0], pat[NLV-1:0], pat[NLV+NHV-1:NLV], "R7");
    expect_state(1, 1, "R7");
    // R1 again: reset from live state
    step(1, 3'b111, '1, '1, "R1");
    step(0, 3'b111, '1, '1, "R1");
    expect_state(0, 0, "R1");
    // R6, R9: exact enable/unmask timing from a clean simultaneous rise
    for (int k = 0; k < S + 3; k++) step(0, 3'b111, 2'b11, 2'b11, "R6");
    step(0, 3'b111, 2'b01, 2'b10, "R9");
    expect_state(1, 1, "R9");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule